// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block puts a register bank in front of a fuse array of 128 words of 32 bits each. Software talks to it over a plain bus: an address, write data, a write strobe and a combinational read-data return. From those registers it can read one fuse word, burn bits into one fuse word, or walk the whole array and copy every word into a bank of shadow registers. Each operation holds a busy flag for a length of time that comes from the strobe and relax counts in a timing register.

The fuse array is a behavioural model: a word can only gain set bits. Burning is two-step. The key 0x3E77 must first be placed in the upper half of the control word, and then a write to the data register launches the burn. A refused request, such as one made while an operation is running or while the error flag is up, is dropped and raises the error flag. The flag stays up until software clears it through the clear alias. The `array_fault` input stands in for a sense failure of the array during a single-word read.

Top module: `otp_ctrl`

## Requirements
- R1: After reset, the control word (offset 0x000) reads 0, the timing register (0x010) reads 0x0003100A, read-data (0x040) reads 0, and every shadow word reads 0.
- R2: The control word has four addresses, each updating the address field (bits 6:0) and the key field (bits 31:16): 0x000 writes plainly, 0x004 ORs the data in, 0x008 clears the bits that are 1 in the data, and 0x00C inverts them.
- R3: Writing 1 to bit 0 of 0x030 starts a read of the addressed word. Busy (control bit 8) is high for exactly STROBE_READ + 2*(RELAX+1) cycles, after which 0x040 holds the fuse word.
- R4: With the key field at 0x3E77, a write to 0x020 ORs the written value into the addressed fuse word. Busy is high for exactly STROBE_PROG + 2*(RELAX+1) cycles, and the key field reads 0 afterwards.
- R5: A write to 0x020 while the key field holds any other value starts nothing: busy stays low and the fuse word is unchanged.
- R6: Setting the reload bit (control bit 10) raises busy for WORDS * (STROBE_READ + 2*(RELAX+1)) cycles, with bit 10 reading 1 throughout. Bit 10 then clears by itself and each shadow word equals its fuse word.
- R7: A read, burn or reload request made while busy or the error flag (control bit 9) is set has no effect on the array or on read-data, and it sets the error flag.
- R8: The error flag is cleared only by a write of bit 9 to the clear alias 0x008. Plain and toggle writes leave it unchanged, and software cannot change busy.
- R9: A read that completes with `array_fault` high returns 0xBADABADA in read-data and sets the error flag.
- R10: The timing register at 0x010 holds STROBE_PROG in bits 11:0, RELAX in 15:12, STROBE_READ in 21:16 and WAIT in 27:22. Bits 31:28 read 0.
- R11: Shadow word n reads at 0x400 + n*0x10. A burn does not change the shadow until the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| array_fault | input | 1 | Sense failure of the array, sampled when a read completes |

## Verification
A write takes effect at the clock edge that samples it, so register contents and the busy bit are compared in the half cycle after that edge. Read data reaches `bus_rdata` in the same cycle as the address because the path is combinational. Operation length is measured by sampling busy once per cycle at the falling edge, starting just after the launching write; the number of high samples must equal the duration computed from the timing fields. Results of a read, burn or reload are compared only after busy has been seen low. Refused requests are checked on the very next sample by confirming that busy stayed low, and later through read-data and the fuse contents.

// File: rtl/otp_ctrl.sv
module otp_ctrl #(
  parameter int          WORDS      = 128,
  parameter int          BUS_AW     = 12,
  parameter logic [15:0] KEY        = 16'h3E77,
  parameter logic [31:0] FAIL_WORD  = 32'hBADA_BADA,
  parameter logic [31:0] TIMING_RST = 32'h0003_100A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic              array_fault
);
  localparam int AW = $clog2(WORDS);
  localparam int CW = 14;
  localparam logic [BUS_AW-1:0] A_TIM  = BUS_AW'('h010);
  localparam logic [BUS_AW-1:0] A_DATA = BUS_AW'('h020);
  localparam logic [BUS_AW-1:0] A_RCTL = BUS_AW'('h030);
  localparam logic [BUS_AW-1:0] A_RDAT = BUS_AW'('h040);
  localparam logic [BUS_AW-1:0] A_SHD  = BUS_AW'('h400);

  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_PROG, OP_LOAD} op_e;

  logic [6:0]    addr_q;
  logic [15:0]   unlock_q;
  logic          busy_q, err_q, reload_q;
  logic [27:0]   timing_q;
  logic [31:0]   data_q, rdata_q;
  logic [AW-1:0] op_addr_q, load_idx_q;
  logic [CW-1:0] cnt_q, load_dur_q;
  op_e           op_q;
  logic [31:0]   fuse_q   [WORDS];
  logic [31:0]   shadow_q [WORDS];

  logic [31:0] ctrl_rd, ctrl_new;
  assign ctrl_rd = {unlock_q, 5'b0, reload_q, err_q, busy_q, 1'b0, addr_q};

  wire       sel_ctrl = (bus_addr[BUS_AW-1:4] == '0) && (bus_addr[1:0] == 2'b00);
  wire [1:0] alias_op = bus_addr[3:2];

  always_comb begin
    case (alias_op)
      2'd0:    ctrl_new = bus_wdata;
      2'd1:    ctrl_new = ctrl_rd | bus_wdata;
      2'd2:    ctrl_new = ctrl_rd & ~bus_wdata;
      default: ctrl_new = ctrl_rd ^ bus_wdata;
    endcase
  end

  wire ctrl_wr = bus_we && sel_ctrl;
  wire err_clr = ctrl_wr && (alias_op == 2'd2) && bus_wdata[9];
  wire rl_req  = ctrl_wr && ctrl_new[10] && !reload_q;
  wire rd_req  = bus_we && (bus_addr == A_RCTL) && bus_wdata[0];
  wire pg_req  = bus_we && (bus_addr == A_DATA) && (unlock_q == KEY);
  wire any_req = rd_req || pg_req || rl_req;
  wire blocked = busy_q || err_q;
  wire start   = any_req && !blocked;
  wire done    = busy_q && (cnt_q == '0);

  wire [CW-1:0] relax2 = (CW'(timing_q[15:12]) + CW'(1)) << 1;
  wire [CW-1:0] rd_dur = CW'(timing_q[21:16]) + relax2;
  wire [CW-1:0] pg_dur = CW'(timing_q[11:0]) + relax2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      unlock_q   <= '0;
      busy_q     <= 1'b0;
      err_q      <= 1'b0;
      reload_q   <= 1'b0;
      timing_q   <= TIMING_RST[27:0];
      data_q     <= '0;
      rdata_q    <= '0;
      op_addr_q  <= '0;
      load_idx_q <= '0;
      cnt_q      <= '0;
      load_dur_q <= '0;
      op_q       <= OP_IDLE;
    end else begin
      if (ctrl_wr) begin
        addr_q   <= ctrl_new[6:0];
        unlock_q <= ctrl_new[31:16];
      end
      if (err_clr) err_q <= 1'b0;
      if (bus_we && bus_addr == A_TIM) timing_q <= bus_wdata[27:0];
      if (bus_we && bus_addr == A_DATA && !busy_q) data_q <= bus_wdata;
      if (any_req && blocked) err_q <= 1'b1;
      if (start) begin
        busy_q     <= 1'b1;
        op_addr_q  <= addr_q[AW-1:0];
        load_idx_q <= '0;
        load_dur_q <= rd_dur;
        if (rd_req) begin
          op_q  <= OP_READ;
          cnt_q <= rd_dur - CW'(1);
        end else if (pg_req) begin
          op_q  <= OP_PROG;
          cnt_q <= pg_dur - CW'(1);
        end else begin
          op_q     <= OP_LOAD;
          reload_q <= 1'b1;
          cnt_q    <= rd_dur - CW'(1);
        end
      end else if (busy_q) begin
        if (!done) cnt_q <= cnt_q - CW'(1);
        else begin
          case (op_q)
            OP_READ: begin
              rdata_q <= array_fault ? FAIL_WORD : fuse_q[op_addr_q];
              if (array_fault) err_q <= 1'b1;
              busy_q <= 1'b0;
              op_q   <= OP_IDLE;
            end
            OP_PROG: begin
              unlock_q <= '0;
              busy_q   <= 1'b0;
              op_q     <= OP_IDLE;
            end
            default: begin
              if (load_idx_q == AW'(WORDS - 1)) begin
                busy_q   <= 1'b0;
                reload_q <= 1'b0;
                op_q     <= OP_IDLE;
              end else begin
                load_idx_q <= load_idx_q + AW'(1);
                cnt_q      <= load_dur_q - CW'(1);
              end
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        fuse_q[i]   <= '0;
        shadow_q[i] <= '0;
      end
    end else begin
      if (done && op_q == OP_PROG) fuse_q[op_addr_q] <= fuse_q[op_addr_q] | data_q;
      if (done && op_q == OP_LOAD) shadow_q[load_idx_q] <= fuse_q[load_idx_q];
    end
  end

  logic [BUS_AW-1:0] shd_off;
  logic              shd_hit;
  assign shd_off = bus_addr - A_SHD;
  assign shd_hit = (bus_addr >= A_SHD) && (shd_off[3:0] == 4'h0) &&
                   (int'(shd_off[BUS_AW-1:4]) < WORDS);

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)                bus_rdata = ctrl_rd;
    else if (bus_addr == A_TIM)  bus_rdata = {4'b0, timing_q};
    else if (bus_addr == A_DATA) bus_rdata = data_q;
    else if (bus_addr == A_RDAT) bus_rdata = rdata_q;
    else if (shd_hit)            bus_rdata = shadow_q[shd_off[AW+3:4]];
  end
endmodule

module otp_ctrl_chk #(
  parameter int          BUS_AW    = 12,
  parameter logic [31:0] FAIL_WORD = 32'hBADA_BADA
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_we,
  input logic              array_fault,
  input logic              busy_q,
  input logic              err_q,
  input logic              reload_q,
  input logic [15:0]       unlock_q,
  input logic [1:0]        op_q,
  input logic [31:0]       rdata_q
);
  localparam logic [BUS_AW-1:0] A_CLR  = BUS_AW'('h008);
  localparam logic [BUS_AW-1:0] A_RCTL = BUS_AW'('h030);

  p_reload_holds_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reload_q |-> busy_q);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(bus_we && bus_addr == A_CLR && bus_wdata[9])) |=> err_q);

  p_busy_request_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bus_we && bus_addr == A_RCTL && bus_wdata[0]) |=> err_q);

  p_key_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && !busy_q && $past(op_q) == 2'd2) |-> (unlock_q == 16'h0));

  p_fault_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && !busy_q && $past(op_q) == 2'd1 && $past(array_fault))
      |-> (rdata_q == FAIL_WORD && err_q));
endmodule

bind otp_ctrl otp_ctrl_chk #(.BUS_AW(BUS_AW), .FAIL_WORD(FAIL_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .array_fault(array_fault), .busy_q(busy_q), .err_q(err_q),
  .reload_q(reload_q), .unlock_q(unlock_q), .op_q(op_q), .rdata_q(rdata_q)
);

// File: tb/tb_otp_ctrl.sv
module tb_otp_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        array_fault = 1'b0;
  int n_chk = 0;
  int n_err = 0;

  otp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .array_fault(array_fault)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0;
    #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1;
    v = bus_rdata;
    bus_addr = '0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (bus_rdata[8] && n < 100000) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h000, v); chk("R1 ctrl", v, 32'h0);
    rd(12'h010, v); chk("R1 timing", v, 32'h0003_100A);
    rd(12'h040, v); chk("R1 read-data", v, 32'h0);
    rd(12'h400, v); chk("R1 shadow0", v, 32'h0);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(12'h000, 32'h0000_0005); rd(12'h000, v); chk("R2 plain", v, 32'h0000_0005);
    wr(12'h004, 32'h0000_0012); rd(12'h004, v); chk("R2 set", v, 32'h0000_0017);
    wr(12'h008, 32'h0000_0003); rd(12'h000, v); chk("R2 clear", v, 32'h0000_0014);
    wr(12'h00C, 32'h0001_0011); rd(12'h000, v); chk("R2 toggle", v, 32'h0001_0005);
    wr(12'h008, 32'hFFFF_007F); rd(12'h000, v); chk("R2 clear all", v, 32'h0);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    wr(12'h010, 32'h0FC5_2123); rd(12'h010, v); chk("R10 fields", v, 32'h0FC5_2123);
    wr(12'h010, 32'hFFFF_FFFF); rd(12'h010, v); chk("R10 top bits", v, 32'h0FFF_FFFF);
    wr(12'h010, 32'h0001_0004); rd(12'h010, v); chk("R10 short", v, 32'h0001_0004);
  endtask

  task automatic t_prog_read();
    logic [31:0] v; int n;
    wr(12'h000, 32'h3E77_0005);
    wr(12'h020, 32'h0000_00F0); count_busy(n); chk("R4 burn cycles", n, 6);
    rd(12'h000, v); chk("R4 key cleared", v, 32'h0000_0005);
    wr(12'h030, 32'h1); count_busy(n); chk("R3 read cycles", n, 3);
    rd(12'h040, v); chk("R3 read data", v, 32'h0000_00F0);
    wr(12'h000, 32'h3E77_0005);
    wr(12'h020, 32'h0F00_0001); count_busy(n);
    wr(12'h030, 32'h1); count_busy(n);
    rd(12'h040, v); chk("R4 OR burn", v, 32'h0F00_00F1);
  endtask

  task automatic t_nokey();
    logic [31:0] v; int n;
    wr(12'h000, 32'h1234_0005);
    wr(12'h020, 32'hFFFF_FFFF); chk("R5 no busy", bus_rdata, 32'h1234_0005);
    wr(12'h000, 32'h0000_0005);
    wr(12'h030, 32'h1); count_busy(n);
    rd(12'h040, v); chk("R5 word kept", v, 32'h0F00_00F1);
  endtask

  task automatic t_reload();
    logic [31:0] v; int n;
    wr(12'h000, 32'h3E77_007F);
    wr(12'h020, 32'h8000_0000); count_busy(n);
    rd(12'h450, v); chk("R11 shadow before reload", v, 32'h0);
    wr(12'h004, 32'h0000_0400);
    chk("R6 reload bit up", {31'b0, bus_rdata[10]}, 32'h1);
    count_busy(n); chk("R6 reload cycles", n, 384);
    rd(12'h000, v); chk("R6 reload bit cleared", v, 32'h0000_007F);
    rd(12'h450, v); chk("R11 shadow5", v, 32'h0F00_00F1);
    rd(12'hBF0, v); chk("R11 shadow127", v, 32'h8000_0000);
    rd(12'h400, v); chk("R6 shadow0", v, 32'h0);
  endtask

  task automatic t_busy_err();
    logic [31:0] v; int n;
    wr(12'h000, 32'h0000_0005);
    wr(12'h030, 32'h1);
    wr(12'h030, 32'h1); count_busy(n);
    rd(12'h000, v); chk("R7 err after busy request", v, 32'h0000_0205);
    rd(12'h040, v); chk("R7 first read intact", v, 32'h0F00_00F1);
    wr(12'h000, 32'h0000_0006);
    wr(12'h030, 32'h1); chk("R7 read refused", bus_rdata, 32'h0000_0206);
    rd(12'h040, v); chk("R7 read-data kept", v, 32'h0F00_00F1);
    wr(12'h000, 32'h3E77_0006);
    wr(12'h020, 32'h0000_FFFF); chk("R7 burn refused", bus_rdata, 32'h3E77_0206);
  endtask

  task automatic t_err_clear();
    logic [31:0] v; int n;
    wr(12'h000, 32'h0000_0106); rd(12'h000, v); chk("R8 plain keeps err", v, 32'h0000_0206);
    wr(12'h00C, 32'h0000_0200); rd(12'h000, v); chk("R8 toggle keeps err", v, 32'h0000_0206);
    wr(12'h008, 32'h0000_0200); rd(12'h000, v); chk("R8 clear alias", v, 32'h0000_0006);
    wr(12'h030, 32'h1); count_busy(n);
    rd(12'h040, v); chk("R7 refused burn left word", v, 32'h0);
  endtask

  task automatic t_fault();
    logic [31:0] v; int n;
    wr(12'h000, 32'h0000_0005);
    array_fault = 1'b1;
    wr(12'h030, 32'h1); count_busy(n);
    array_fault = 1'b0;
    rd(12'h040, v); chk("R9 fail word", v, 32'hBADA_BADA);
    rd(12'h000, v); chk("R9 err set", v, 32'h0000_0205);
    wr(12'h008, 32'h0000_0200);
    wr(12'h030, 32'h1); count_busy(n);
    rd(12'h040, v); chk("R9 recovery read", v, 32'h0F00_00F1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_alias();
    t_timing();
    t_prog_read();
    t_nokey();
    t_reload();
    t_busy_err();
    t_err_clear();
    t_fault();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule